// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Accumulator Commands

This block is a fixed-point multiply-accumulate datapath. It has a 24 x 24 signed multiplier and a 48-bit accumulator, and a small command sequencer drives it. A host sends a 16-bit command code with a one-clock start strobe. The code selects one of six operations: clear the accumulator, multiply two operands and add the product, load the accumulator from a 32-bit or a 48-bit value, or read the accumulator back as a 32-bit or a 48-bit value.

Each command occupies the unit for a fixed number of clocks, and the unit reports busy for that whole time. It raises done for one clock on the final cycle of the command. The read-back value appears on the result bus in that same cycle and stays there until the next read-back command. The unit ignores a code it does not recognise: the command takes the short clock count, leaves all state as it was, and flags the code as illegal.

Top module: `mac_cmd_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, busy_o, done_o and illegal_o are low and result_o is zero. The accumulator also resets to zero, so a 48-bit read issued immediately returns zero.
- R2: When start_i is high at a rising edge and busy_o is low, the command is accepted. cmd_i, opa_i, opb_i and load_i are captured at that edge, and busy_o goes high in the next cycle.
- R3: Each accepted command keeps busy_o high for exactly N cycles. done_o is high only in the N-th of those cycles, and busy_o is low in the cycle after it. N is 4 for code 0x4F00, 8 for 0x4F02, 11 for 0x4F04, 9 for 0x4F05, 9 for 0x4F07 and 7 for 0x4F08.
- R4: Code 0x4F02 treats opa_i and opb_i as two's-complement 24-bit values. It sign-extends their product to 48 bits, adds it to the accumulator, and wraps modulo 2^48 on overflow.
- R5: Code 0x4F00 sets the accumulator to zero.
- R6: Code 0x4F05 loads the accumulator with load_i[31:0] sign-extended to 48 bits. Code 0x4F07 loads the accumulator with all 48 bits of load_i.
- R7: Code 0x4F04 places the whole 48-bit accumulator on result_o. Code 0x4F08 places the accumulator's low 32 bits on result_o[31:0] with result_o[47:32] zero. In both cases the value is present from the done cycle onward.
- R8: A start_i strobe while busy_o is high is ignored. The running command keeps its clock count and its effect, and the accumulator does not see the ignored command.
- R9: Any code outside the six above completes in 4 cycles and raises illegal_o only in its done cycle. It leaves the accumulator and result_o unchanged.
- R10: result_o changes only in a done cycle of a read-back command. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, sampled when idle |
| cmd_i | input | 16 | Command code |
| opa_i | input | 24 | Multiplicand, two's-complement |
| opb_i | input | 24 | Multiplier, two's-complement |
| load_i | input | 48 | Value for the load commands |
| result_o | output | 48 | Read-back value, held between reads |
| busy_o | output | 1 | High while a command runs |
| done_o | output | 1 | One-clock pulse on a command's final cycle |
| illegal_o | output | 1 | High in the done cycle of an unrecognised code |

## Verification
Busy is due one cycle after the accepting edge. Done and any new result_o value are due in the N-th busy cycle, N being the command's clock count, and idle is due one cycle after done. The bench drives inputs on falling edges and samples once per falling edge, counting busy cycles from the first sample after acceptance. It compares that count with N, and it reads result_o and illegal_o in the sample where done is seen. Accumulator effects are observed through a later 48-bit or 32-bit read. The values are checked against a 48-bit arithmetic model built from a near-complete sweep of signed operand corner values.

// File: rtl/mac_cmd_pkg.sv
package mac_cmd_pkg;

    typedef enum logic [2:0] {
        OP_CLR  = 3'd0,
        OP_MAC  = 3'd1,
        OP_RD48 = 3'd2,
        OP_WR32 = 3'd3,
        OP_WR48 = 3'd4,
        OP_RD32 = 3'd5,
        OP_BAD  = 3'd6
    } mac_op_e;

    localparam logic [15:0] CODE_CLR  = 16'h4F00;
    localparam logic [15:0] CODE_MAC  = 16'h4F02;
    localparam logic [15:0] CODE_RD48 = 16'h4F04;
    localparam logic [15:0] CODE_WR32 = 16'h4F05;
    localparam logic [15:0] CODE_WR48 = 16'h4F07;
    localparam logic [15:0] CODE_RD32 = 16'h4F08;

endpackage

// File: rtl/mac_cmd_decode.sv
module mac_cmd_decode
    import mac_cmd_pkg::*;
#(
    parameter int CNTW     = 4,
    parameter int CYC_CLR  = 4,
    parameter int CYC_MAC  = 8,
    parameter int CYC_RD48 = 11,
    parameter int CYC_RD32 = 7,
    parameter int CYC_WR   = 9,
    parameter int CYC_BAD  = 4
) (
    input  logic [15:0]     cmd_i,
    output mac_op_e         op_o,
    output logic [CNTW-1:0] cyc_o
);

    always_comb begin
        unique case (cmd_i)
            CODE_CLR:  begin op_o = OP_CLR;  cyc_o = CNTW'(CYC_CLR);  end
            CODE_MAC:  begin op_o = OP_MAC;  cyc_o = CNTW'(CYC_MAC);  end
            CODE_RD48: begin op_o = OP_RD48; cyc_o = CNTW'(CYC_RD48); end
            CODE_WR32: begin op_o = OP_WR32; cyc_o = CNTW'(CYC_WR);   end
            CODE_WR48: begin op_o = OP_WR48; cyc_o = CNTW'(CYC_WR);   end
            CODE_RD32: begin op_o = OP_RD32; cyc_o = CNTW'(CYC_RD32); end
            default:   begin op_o = OP_BAD;  cyc_o = CNTW'(CYC_BAD);  end
        endcase
    end

endmodule

// File: rtl/mac_cmd_mul.sv
module mac_cmd_mul #(
    parameter int OPW  = 24,
    parameter int ACCW = 48
) (
    input  logic [OPW-1:0]  a_i,
    input  logic [OPW-1:0]  b_i,
    output logic [ACCW-1:0] prod_o
);

    localparam int PW = 2 * OPW;

    logic signed [PW-1:0] full_prod;

    assign full_prod = PW'($signed(a_i)) * PW'($signed(b_i));

    generate
        if (ACCW > PW) begin : g_ext
            assign prod_o = {{(ACCW-PW){full_prod[PW-1]}}, full_prod};
        end else if (ACCW == PW) begin : g_same
            assign prod_o = full_prod;
        end else begin : g_trunc
            assign prod_o = full_prod[ACCW-1:0];
        end
    endgenerate

endmodule

// File: rtl/mac_cmd_unit.sv
module mac_cmd_unit
    import mac_cmd_pkg::*;
#(
    parameter int OPW      = 24,
    parameter int ACCW     = 48,
    parameter int SHORTW   = 32,
    parameter int CNTW     = 4,
    parameter int CYC_CLR  = 4,
    parameter int CYC_MAC  = 8,
    parameter int CYC_RD48 = 11,
    parameter int CYC_RD32 = 7,
    parameter int CYC_WR   = 9,
    parameter int CYC_BAD  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [15:0]     cmd_i,
    input  logic [OPW-1:0]  opa_i,
    input  logic [OPW-1:0]  opb_i,
    input  logic [ACCW-1:0] load_i,
    output logic [ACCW-1:0] result_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            illegal_o
);

    localparam int EXTW = ACCW - SHORTW;

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        mac_op_e         op;
        logic [OPW-1:0]  a;
        logic [OPW-1:0]  b;
        logic [ACCW-1:0] ld;
        logic [ACCW-1:0] acc;
        logic [ACCW-1:0] res;
        logic            illegal;
    } state_t;

    state_t          st_d, st_q;
    mac_op_e         dec_op;
    logic [CNTW-1:0] dec_cyc;
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] ld_short;

    mac_cmd_decode #(
        .CNTW    (CNTW),
        .CYC_CLR (CYC_CLR),
        .CYC_MAC (CYC_MAC),
        .CYC_RD48(CYC_RD48),
        .CYC_RD32(CYC_RD32),
        .CYC_WR  (CYC_WR),
        .CYC_BAD (CYC_BAD)
    ) u_decode (
        .cmd_i (cmd_i),
        .op_o  (dec_op),
        .cyc_o (dec_cyc)
    );

    mac_cmd_mul #(
        .OPW (OPW),
        .ACCW(ACCW)
    ) u_mul (
        .a_i   (st_q.a),
        .b_i   (st_q.b),
        .prod_o(prod)
    );

    // sign-extended short load value
    assign ld_short = {{EXTW{st_q.ld[SHORTW-1]}}, st_q.ld[SHORTW-1:0]};

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = dec_cyc - CNTW'(1);
                st_d.op   = dec_op;
                st_d.a    = opa_i;
                st_d.b    = opb_i;
                st_d.ld   = load_i;
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNTW'(1);
            end
            // effects land on the edge that enters the final cycle
            if (st_q.cnt == CNTW'(1)) begin
                unique case (st_q.op)
                    OP_CLR:  st_d.acc = '0;
                    OP_MAC:  st_d.acc = st_q.acc + prod;
                    OP_WR32: st_d.acc = ld_short;
                    OP_WR48: st_d.acc = st_q.ld;
                    OP_RD48: st_d.res = st_q.acc;
                    OP_RD32: st_d.res = {{EXTW{1'b0}}, st_q.acc[SHORTW-1:0]};
                    default: st_d.illegal = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, op: OP_CLR, a: '0, b: '0,
                      ld: '0, acc: '0, res: '0, illegal: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.busy && (st_q.cnt == '0);
    assign illegal_o = st_q.illegal;
    assign result_o  = st_q.res;

endmodule

// File: rtl/mac_cmd_chk.sv
module mac_cmd_chk #(
    parameter int ACCW = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [ACCW-1:0] result_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o
);

    // R3
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R3
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R9
    illegal_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind mac_cmd_unit mac_cmd_chk #(.ACCW(ACCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .result_o (result_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .illegal_o(illegal_o)
);

// File: tb/mac_cmd_unit_tb_top.sv
module mac_cmd_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cmd_i = '0;
    logic [23:0] opa_i = '0;
    logic [23:0] opb_i = '0;
    logic [47:0] load_i = '0;
    logic [47:0] result_o;
    logic        busy_o, done_o, illegal_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [47:0] model_acc = '0;
    logic [47:0] last_res = '0;
    logic [47:0] r;

    always #5 clk = ~clk;

    mac_cmd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .opa_i(opa_i), .opb_i(opb_i), .load_i(load_i), .result_o(result_o),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] c, input logic [23:0] a, input logic [23:0] b,
                       input logic [47:0] ld, input int exp_n, input bit exp_ill,
                       input bit inject, input string req, output logic [47:0] res);
        int n;
        @(negedge clk);
        start_i = 1'b1; cmd_i = c; opa_i = a; opb_i = b; load_i = ld;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk(busy_o, "R2 busy after accept", 64'(busy_o), 64'd1);
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
            if (inject && n == 3) begin
                start_i = 1'b1; cmd_i = 16'h4F00;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk(n == exp_n, req, 64'(n), 64'(exp_n));
        chk(illegal_o == exp_ill, "R9 illegal flag at done", 64'(illegal_o), 64'(exp_ill));
        res = result_o;
        @(negedge clk);
        chk(!busy_o && !done_o, "R3 idle after done", 64'({busy_o, done_o}), 64'd0);
        chk(result_o == res, "R10 result held after done", 64'(result_o), 64'(res));
    endtask

    task automatic read48(input string req);
        logic [47:0] v;
        run(16'h4F04, '0, '0, '0, 11, 1'b0, 1'b0, "R3 read48 clock count", v);
        chk(v == model_acc, req, 64'(v), 64'(model_acc));
        last_res = v;
    endtask

    task automatic read32(input string req);
        logic [47:0] v;
        logic [47:0] e;
        e = {16'h0000, model_acc[31:0]};
        run(16'h4F08, '0, '0, '0, 7, 1'b0, 1'b0, "R3 read32 clock count", v);
        chk(v == e, req, 64'(v), 64'(e));
        last_res = v;
    endtask

    task automatic mac(input logic [23:0] a, input logic [23:0] b, input bit inject);
        logic [47:0] v;
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        run(16'h4F02, a, b, '0, 8, 1'b0, inject, "R3 mac clock count", v);
        chk(v == last_res, "R10 result unchanged by mac", 64'(v), 64'(last_res));
        model_acc = model_acc + p[47:0];
    endtask

    initial begin
        logic [23:0] vals [8];
        vals[0] = 24'h000000; vals[1] = 24'h000001; vals[2] = 24'hFFFFFF;
        vals[3] = 24'h7FFFFF; vals[4] = 24'h800000; vals[5] = 24'h123456;
        vals[6] = 24'hFFFFFD; vals[7] = 24'h000002;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !illegal_o && result_o == '0, "R1 outputs in reset",
            64'({busy_o, done_o, illegal_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !illegal_o && result_o == '0, "R1 outputs after reset",
            64'(result_o), 64'd0);
        read48("R1 accumulator zero after reset");

        // R4 sweep of signed corner products, accumulated with wrap
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                mac(vals[i], vals[j], 1'b0);
                read48("R4 accumulated signed product");
            end
            read32("R7 low word read zero-extended");
        end

        // R5 clear
        run(16'h4F00, '0, '0, '0, 4, 1'b0, 1'b0, "R3 clear clock count", r);
        model_acc = '0;
        read48("R5 accumulator cleared");

        // R6 loads
        run(16'h4F05, '0, '0, 48'hABCD_8000_0001, 9, 1'b0, 1'b0, "R3 load32 clock count", r);
        model_acc = 48'hFFFF_8000_0001;
        read48("R6 load32 sign-extends negative");
        run(16'h4F05, '0, '0, 48'hFFFF_1234_5678, 9, 1'b0, 1'b0, "R3 load32 clock count", r);
        model_acc = 48'h0000_1234_5678;
        read48("R6 load32 sign-extends positive");
        run(16'h4F07, '0, '0, 48'h7FFF_FFFF_FFFF, 9, 1'b0, 1'b0, "R3 load48 clock count", r);
        model_acc = 48'h7FFF_FFFF_FFFF;
        read48("R6 load48 full value");
        read32("R7 low word of loaded value");

        // R4 wrap past the top of the 48-bit range
        mac(24'h000001, 24'h000001, 1'b0);
        read48("R4 wrap on overflow");
        chk(model_acc == 48'h8000_0000_0000, "R4 model wrap value", 64'(model_acc),
            64'h8000_0000_0000);

        // R8 a clear strobe during a mac is ignored
        mac(24'h000003, 24'h000005, 1'b1);
        read48("R8 strobe while busy ignored");

        // R9 unrecognised codes
        begin
            logic [15:0] bad [5];
            bad[0] = 16'h4F01; bad[1] = 16'h4F03; bad[2] = 16'h0000;
            bad[3] = 16'h4F06; bad[4] = 16'hFFFF;
            for (int k = 0; k < 5; k++) begin
                run(bad[k], 24'h7FFFFF, 24'h7FFFFF, 48'h1, 4, 1'b1, 1'b0,
                    "R9 illegal code clock count", r);
                chk(r == last_res, "R9 result untouched by illegal code", 64'(r), 64'(last_res));
                read48("R9 accumulator untouched by illegal code");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule